// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns an oscillator clock-enable strobe (nominally 32.768 kHz) into a once-per-second tick. The tick is a single-cycle pulse in the system clock domain. A 3-bit trim code applies a signed frequency correction in steps of 20 ppm. The divide ratio itself is never changed. Instead, the block lengthens or shortens an individual second by one oscillator count at a time. Over many seconds, the average tick rate then moves by the coded amount.

A phase accumulator, counted in millionths of an oscillator count, sets the timing of the corrections. At every second boundary the accumulator grows by the correction magnitude times the nominal divide. Each time it passes the modulus, the second that follows gets one count fewer (positive trim) or one count more (negative trim). The trim code is read only at the boundary, so a second that is already in progress is never cut short. A debug counter records every count that is inserted or dropped, which lets the long-run average be checked against the code.

Top module: `seconds_trim_prescaler`

## Requirements
- R1: With trim code 000 or 100, every second spans exactly DIV oscillator enables (DIV = 32768 by default).
- R2: `sec_tick_o` is high for exactly one clock cycle, in the cycle after the clock edge that consumes the enable closing a second. It never pulses while no enables arrive.
- R3: The trim code is sign-magnitude. Bit 2 set means negative (slower, longer seconds). Bit 2 clear means positive (faster, shorter seconds). Bit 1 weighs 40 ppm and bit 0 weighs 20 ppm, and the two add, for a range of -60 to +60 ppm.
- R4: At each second boundary the phase grows by |ppm| x DIV. Each time it reaches PHASE_MOD (1,000,000 by default), PHASE_MOD is subtracted and the next second is shortened by one enable (positive) or lengthened by one (negative).
- R5: Over a window of N seconds at a constant code, the number of corrections equals floor((phase at start + N x |ppm| x DIV) / PHASE_MOD).
- R6: The trim code is sampled only on the edge that closes a second. Any value it holds earlier in the second has no effect.
- R7: `corr_count_o` rises by the number of corrections scheduled, on the same edge as the tick that opens the corrected second. At all other times it holds its value, and it wraps at its width.
- R8: After reset, the tick is low, the correction count is zero, the phase is zero, and the first second is nominal.
- R9: When one boundary crosses the modulus more than once, all crossings apply to the next second, up to the maximum the parameters allow.
- R10: The leftover phase carries across code changes, including changes of sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | One-cycle strobe per oscillator period |
| trim_code_i | input | 3 | Sign-magnitude trim code, bit 2 is the sign |
| sec_tick_o | output | 1 | One-cycle pulse per second |
| corr_count_o | output | CORR_W | Running count of inserted or dropped enables |

## Verification
The hardest cases to reach are two: a boundary where the phase crosses the modulus twice, and a code that changes mid-second and then changes back. The bench runs with a small divide and modulus, so a single boundary at 40 or 60 ppm produces double crossings. It also drives a decoy code for the first half of each second and the real code for the second half. Leftover phase is carried through changes of sign, and irregular gaps between enables show that the second length depends only on counted enables.

// File: rtl/trim_prescaler_pkg.sv
package trim_prescaler_pkg;
  typedef struct packed {
    logic       slow;   // 1: negative ppm, longer seconds
    logic [1:0] steps;  // bit1 = 2 steps, bit0 = 1 step
  } trim_code_t;
endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import trim_prescaler_pkg::*;
#(
  parameter int DIV      = 32768,
  parameter int STEP_PPM = 20,
  parameter int INC_W    = 21
) (
  input  logic [2:0]       code_i,
  output logic             slow_o,
  output logic [INC_W-1:0] inc_o
);
  localparam int UNIT = STEP_PPM * DIV;

  trim_code_t code;
  assign code   = trim_code_t'(code_i);
  assign slow_o = code.slow;
  assign inc_o  = INC_W'(UNIT) * INC_W'(code.steps);
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int PHASE_MOD = 1000000,
  parameter int MAX_CORR  = 2,
  parameter int INC_W     = 21,
  parameter int ACC_W     = 22,
  parameter int Q_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [Q_W-1:0]   q_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] rem;
  logic [Q_W-1:0]   q;

  always_comb begin
    rem = acc_q + ACC_W'(inc_i);
    q   = '0;
    for (int k = 0; k < MAX_CORR; k++) begin
      if (rem >= ACC_W'(PHASE_MOD)) begin
        rem = rem - ACC_W'(PHASE_MOD);
        q   = q + Q_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= rem;
  end

  assign q_o = q;
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int DIV   = 32768,
  parameter int CNT_W = 16,
  parameter int Q_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slow_i,
  input  logic [Q_W-1:0]   q_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] cnt_q, len_q;

  assign wrap_o = en_i && (cnt_q == len_q - CNT_W'(1));
  assign len_o  = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CNT_W'(DIV);
    end else if (wrap_o) begin
      cnt_q <= '0;
      len_q <= slow_i ? CNT_W'(DIV) + CNT_W'(q_i) : CNT_W'(DIV) - CNT_W'(q_i);
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/seconds_trim_prescaler.sv
module seconds_trim_prescaler #(
  parameter int DIV       = 32768,
  parameter int STEP_PPM  = 20,
  parameter int PHASE_MOD = 1000000,
  parameter int CORR_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic [2:0]        trim_code_i,
  output logic              sec_tick_o,
  output logic [CORR_W-1:0] corr_count_o
);
  localparam int INC_MAX  = 3 * STEP_PPM * DIV;
  localparam int MAX_CORR = (PHASE_MOD - 1 + INC_MAX) / PHASE_MOD;
  localparam int INC_W    = $clog2(INC_MAX + 1);
  localparam int ACC_W    = $clog2(PHASE_MOD + INC_MAX + 1);
  localparam int Q_W      = $clog2(MAX_CORR + 1);
  localparam int CNT_W    = $clog2(DIV + MAX_CORR + 1);

  logic             slow_w, wrap_w;
  logic [INC_W-1:0] inc_w;
  logic [Q_W-1:0]   q_w;
  logic [CNT_W-1:0] len_w;
  logic             tick_q;
  logic [CORR_W-1:0] corr_q;

  trim_decode #(.DIV(DIV), .STEP_PPM(STEP_PPM), .INC_W(INC_W)) u_decode (
    .code_i (trim_code_i),
    .slow_o (slow_w),
    .inc_o  (inc_w)
  );

  phase_accum #(
    .PHASE_MOD(PHASE_MOD), .MAX_CORR(MAX_CORR),
    .INC_W(INC_W), .ACC_W(ACC_W), .Q_W(Q_W)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (wrap_w),
    .inc_i  (inc_w),
    .q_o    (q_w)
  );

  div_counter #(.DIV(DIV), .CNT_W(CNT_W), .Q_W(Q_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en_i),
    .slow_i (slow_w),
    .q_i    (q_w),
    .wrap_o (wrap_w),
    .len_o  (len_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      corr_q <= '0;
    end else begin
      tick_q <= wrap_w;
      if (wrap_w) corr_q <= corr_q + CORR_W'(q_w);
    end
  end

  assign sec_tick_o   = tick_q;
  assign corr_count_o = corr_q;
endmodule

// File: rtl/seconds_trim_prescaler_chk.sv
module seconds_trim_prescaler_chk #(
  parameter int DIV      = 32768,
  parameter int MAX_CORR = 2,
  parameter int CORR_W   = 16,
  parameter int CNT_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              osc_en_i,
  input logic [2:0]        trim_code_i,
  input logic              sec_tick_o,
  input logic [CORR_W-1:0] corr_count_o,
  input logic [CNT_W-1:0]  len_i
);
  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  assert_tick_after_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> $past(osc_en_i));

  assert_corr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_o |-> $stable(corr_count_o));

  assert_corr_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> (CORR_W'(corr_count_o - $past(corr_count_o)) <= CORR_W'(MAX_CORR)));

  assert_zero_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_o && $past(trim_code_i[1:0]) == 2'b00) |-> $stable(corr_count_o));

  assert_sign_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> ($past(trim_code_i[2]) ? (len_i >= CNT_W'(DIV)) : (len_i <= CNT_W'(DIV))));
endmodule

bind seconds_trim_prescaler seconds_trim_prescaler_chk #(
  .DIV(DIV), .MAX_CORR(MAX_CORR), .CORR_W(CORR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .osc_en_i     (osc_en_i),
  .trim_code_i  (trim_code_i),
  .sec_tick_o   (sec_tick_o),
  .corr_count_o (corr_count_o),
  .len_i        (len_w)
);

// File: tb/seconds_trim_prescaler_tb.sv
module seconds_trim_prescaler_tb;
  localparam int DIV    = 50;
  localparam int STEP   = 20;
  localparam int MOD    = 1500;
  localparam int CORR_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              osc_en_i = 1'b0;
  logic [2:0]        trim_code_i = 3'b000;
  logic              sec_tick_o;
  logic [CORR_W-1:0] corr_count_o;

  typedef struct { int len; int corr; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  int acc = 0, cur_len = DIV, corr_tot = 0;
  int en_cnt = 0;
  bit mon_on = 1'b0, prev_tick = 1'b0, done = 1'b0;

  always #4 clk_i = ~clk_i;

  seconds_trim_prescaler #(.DIV(DIV), .STEP_PPM(STEP), .PHASE_MOD(MOD), .CORR_W(CORR_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i), .trim_code_i(trim_code_i),
    .sec_tick_o(sec_tick_o), .corr_count_o(corr_count_o));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // drives one second; code sampled at its closing edge, decoy in first half
  task automatic run_second(input logic [2:0] code, input logic [2:0] decoy,
                            input int gap, input string tag);
    exp_t e;
    int mag, sum, q;
    mag = (code[1] ? 40 : 0) + (code[0] ? 20 : 0);
    sum = acc + mag * DIV;
    q = 0;
    while (sum >= MOD) begin sum -= MOD; q++; end
    acc = sum;
    corr_tot += q;
    e.len = cur_len; e.corr = corr_tot; e.tag = tag;
    exp_q.push_back(e);
    for (int i = 0; i < e.len; i++) begin
      repeat (gap) begin @(posedge clk_i); #1 osc_en_i = 1'b0; end
      @(posedge clk_i); #1 osc_en_i = 1'b1;
      trim_code_i = (i < e.len / 2) ? decoy : code;
    end
    cur_len = code[2] ? DIV + q : DIV - q;
  endtask

  task automatic go_idle(input int n);
    @(posedge clk_i); #1 osc_en_i = 1'b0;
    repeat (n) @(posedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (sec_tick_o) begin
        check(!prev_tick, "R2 tick width", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected tick", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(en_cnt == e.len, {e.tag, " second length"}, en_cnt, e.len);
          check(int'(corr_count_o) == e.corr, {"R7 ", e.tag, " corr count"},
                int'(corr_count_o), e.corr);
        end
        en_cnt = 0;
      end
      prev_tick = sec_tick_o;
      if (osc_en_i) en_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (5) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(sec_tick_o == 1'b0, "R8 reset tick", sec_tick_o, 0);
    check(corr_count_o == '0, "R8 reset count", int'(corr_count_o), 0);
    mon_on = 1'b1;

    run_second(3'b000, 3'b011, 0, "R8 R1");
    run_second(3'b000, 3'b000, 0, "R1");
    run_second(3'b100, 3'b111, 1, "R1");
    run_second(3'b100, 3'b100, 0, "R1");
    for (int s = 0; s < 4; s++) run_second(3'b001, 3'b001, 0, "R4");
    for (int s = 0; s < 3; s++) run_second(3'b011, 3'b101, 1, "R9 R3");
    for (int s = 0; s < 3; s++) run_second(3'b101, 3'b011, 0, "R10 R6 R3");
    for (int s = 0; s < 3; s++) run_second(3'b111, 3'b000, 2, "R9 R3");
    for (int s = 0; s < 3; s++) run_second(3'b010, 3'b110, 0, "R6 R4");
    for (int s = 0; s < 2; s++) run_second(3'b110, 3'b010, 1, "R10 R3");

    // long-run average at +20 ppm
    run_second(3'b001, 3'b001, 0, "R5");
    go_idle(5);
    @(negedge clk_i);
    c0 = int'(corr_count_o);
    for (int s = 0; s < 30; s++) run_second(3'b001, 3'b001, (s % 3 == 0) ? 1 : 0, "R5");
    go_idle(DIV * 2);
    @(negedge clk_i);
    check(int'(corr_count_o) - c0 == (30 * 20 * DIV) / MOD, "R5 window corrections",
          int'(corr_count_o) - c0, (30 * 20 * DIV) / MOD);

    // no enables: no tick, count held
    c0 = int'(corr_count_o);
    repeat (300) @(posedge clk_i);
    @(negedge clk_i);
    check(int'(corr_count_o) == c0, "R2 idle hold", int'(corr_count_o), c0);
    check(exp_q.size() == 0, "R2 missing ticks", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule